// File: doc/BRIEF.md
# Interlaken Lane Frame Synchronizer

This block takes one Interlaken lane after 67-bit block alignment and finds where each metaframe starts. A metaframe is a fixed, programmed number of valid words. Its first word is a synchronization control word and its second word carries the scrambler state. The block hunts for a synchronization word and follows the lane from that point. It declares lock only after synchronization words have arrived at four consecutive metaframe boundaries, each boundary exactly one metaframe length after the previous one.

Once locked, the block checks the scrambler state word of every metaframe. A run of three consecutive failed checks drops lock and sends the block back to the hunt. A single good check clears the failure run. Lock therefore has hysteresis in both directions. The block gives downstream logic a lock flag, a metaframe-start strobe, a per-check failure strobe, the current failure run length and a loss-of-lock strobe. Descrambling and block alignment are not done here.

Top module: `ilkn_frame_sync`

## Requirements
- R1: While and right after reset, o_locked, o_mf_start, o_mismatch and o_lock_lost are 0, o_miss_cnt is 0, and the block is hunting for a synchronization word.
- R2: Word classes are decoded from i_word as follows. A word is a control word when bits [65:64] are 2'b10. A sync word is a control word whose bits [63:0] equal 64'h78F6_78F6_78F6_78F6. A scrambler state word is a control word whose bits [63:58] equal 6'b001010, and its state field is bits [57:0]. Every other word, including one with header 2'b01 and any payload, is neither.
- R3: o_locked rises in the cycle after the fourth sync word has been accepted, provided the four sync words sit at consecutive metaframe boundaries spaced i_mf_len valid words apart. It is still 0 after only three.
- R4: While confirming, a non-sync word at a boundary, or a sync word at any other index, clears the sync count and returns the block to the hunt. Four new correctly spaced sync words are then needed.
- R5: A metaframe holds the sync word at index 0 and the scrambler state word at index 1. While locked, the index-1 word fails its check when it is not a scrambler state word, or when its state field differs from the field of the last scrambler state word seen at index 1. That reference field is captured during confirmation and during lock.
- R6: o_mf_start is a one-cycle pulse in the cycle after a sync word is accepted at index 0 while the block is already locked. It does not pulse for the word that completes lock.
- R7: Each failed check gives a one-cycle o_mismatch pulse, and o_miss_cnt counts consecutive failures. The third consecutive failure clears o_locked and o_miss_cnt and pulses o_lock_lost, all in the cycle after that word. The hunt then restarts.
- R8: A passing scrambler state check while locked returns o_miss_cnt to 0.
- R9: While locked, a missing sync word at index 0, or a sync word at another index, leaves o_locked and the metaframe position unchanged, and no o_mf_start pulse is produced for it.
- R10: Cycles with i_valid low are ignored: they do not advance the metaframe position and cause no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | i_word carries a lane word this cycle |
| i_word | input | 67 | Block-aligned lane word |
| i_mf_len | input | LEN_W (14) | Metaframe length in words, 4 or more |
| o_locked | output | 1 | Metaframe lock held |
| o_mf_start | output | 1 | Sync word accepted at a boundary while locked |
| o_mismatch | output | 1 | Scrambler state check failed |
| o_miss_cnt | output | MISS_W (2) | Current run of consecutive failed checks |
| o_lock_lost | output | 1 | Lock dropped after the failure limit |

## Verification
If the position counter drifts, o_mf_start stops pulsing one metaframe after the slip, because sync words no longer land on index 0. The scrambler check then moves to the wrong word, so o_mismatch starts firing and lock drops three metaframes later. A wrong sync count shows up as o_locked rising one or more metaframes early or late relative to the fourth boundary. A stale scrambler reference or a failure run that is not cleared shows on o_miss_cnt at the next index-1 word. The bench compares every port against a reference model on every cycle, so any of these faults is seen within one metaframe of its first visible effect.

// File: rtl/ilkn_fs_pkg.sv
package ilkn_fs_pkg;

    localparam int WORD_W  = 67;
    localparam int STATE_W = 58;

    localparam logic [1:0]  HDR_CTRL     = 2'b10;
    localparam logic [63:0] SYNC_PATTERN = 64'h78F6_78F6_78F6_78F6;
    localparam logic [5:0]  SCR_TYPE     = 6'b001010;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } fs_state_e;

    typedef struct packed {
        logic               is_sync;
        logic               is_scr;
        logic [STATE_W-1:0] scr_state;
    } word_info_t;

    function automatic word_info_t classify(input logic [WORD_W-1:0] w);
        word_info_t r;
        logic ctrl;
        ctrl        = (w[65:64] == HDR_CTRL);
        r.is_sync   = ctrl && (w[63:0] == SYNC_PATTERN);
        r.is_scr    = ctrl && (w[63:58] == SCR_TYPE);
        r.scr_state = w[STATE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/ilkn_fs_classify.sv
module ilkn_fs_classify
    import ilkn_fs_pkg::*;
(
    input  logic [WORD_W-1:0] i_word,
    output word_info_t        o_info
);
    always_comb o_info = classify(i_word);
endmodule

// File: rtl/ilkn_fs_position.sv
module ilkn_fs_position #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_restart,
    input  logic             i_advance,
    input  logic [LEN_W-1:0] i_len,
    output logic [LEN_W-1:0] o_pos
);
    logic last_idx;
    assign last_idx = (o_pos == i_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            o_pos <= '0;
        else if (i_restart)
            o_pos <= LEN_W'(1);
        else if (i_advance)
            o_pos <= last_idx ? '0 : o_pos + LEN_W'(1);
    end
endmodule

// File: rtl/ilkn_fs_lock_fsm.sv
module ilkn_fs_lock_fsm
    import ilkn_fs_pkg::*;
#(
    parameter int LEN_W       = 14,
    parameter int SYNC_NEEDED = 4,
    parameter int MISS_LIMIT  = 3,
    localparam int CNT_W  = $clog2(SYNC_NEEDED + 1),
    localparam int MISS_W = $clog2(MISS_LIMIT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  word_info_t        i_info,
    input  logic [LEN_W-1:0]  i_pos,
    output fs_state_e         o_state,
    output logic              o_restart,
    output logic              o_advance,
    output logic              o_mf_start,
    output logic              o_mismatch,
    output logic              o_lock_lost,
    output logic [MISS_W-1:0] o_miss_cnt
);
    fs_state_e          state;
    logic [CNT_W-1:0]   sync_cnt;
    logic [STATE_W-1:0] ref_state;
    logic               at_head, at_scr, check_bad;

    assign at_head   = (i_pos == '0);
    assign at_scr    = (i_pos == LEN_W'(1));
    assign check_bad = !i_info.is_scr || (i_info.scr_state != ref_state);

    assign o_restart = i_valid && (state == ST_HUNT) && i_info.is_sync;
    assign o_advance = i_valid && (state != ST_HUNT);
    assign o_state   = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_HUNT;
            sync_cnt    <= '0;
            ref_state   <= '0;
            o_miss_cnt  <= '0;
            o_mf_start  <= 1'b0;
            o_mismatch  <= 1'b0;
            o_lock_lost <= 1'b0;
        end else begin
            o_mf_start  <= 1'b0;
            o_mismatch  <= 1'b0;
            o_lock_lost <= 1'b0;
            if (i_valid) begin
                unique case (state)
                    ST_HUNT: begin
                        if (i_info.is_sync) begin
                            state    <= ST_CONFIRM;
                            sync_cnt <= CNT_W'(1);
                        end
                    end
                    ST_CONFIRM: begin
                        if (at_head) begin
                            if (!i_info.is_sync) begin
                                state    <= ST_HUNT;
                                sync_cnt <= '0;
                            end else if (sync_cnt == CNT_W'(SYNC_NEEDED - 1)) begin
                                state      <= ST_LOCKED;
                                o_miss_cnt <= '0;
                            end else begin
                                sync_cnt <= sync_cnt + CNT_W'(1);
                            end
                        end else if (i_info.is_sync) begin
                            state    <= ST_HUNT;
                            sync_cnt <= '0;
                        end else if (at_scr && i_info.is_scr) begin
                            ref_state <= i_info.scr_state;
                        end
                    end
                    ST_LOCKED: begin
                        if (at_head && i_info.is_sync)
                            o_mf_start <= 1'b1;
                        if (at_scr) begin
                            if (i_info.is_scr)
                                ref_state <= i_info.scr_state;
                            if (check_bad) begin
                                o_mismatch <= 1'b1;
                                if (o_miss_cnt == MISS_W'(MISS_LIMIT - 1)) begin
                                    state       <= ST_HUNT;
                                    sync_cnt    <= '0;
                                    o_miss_cnt  <= '0;
                                    o_lock_lost <= 1'b1;
                                end else begin
                                    o_miss_cnt <= o_miss_cnt + MISS_W'(1);
                                end
                            end else begin
                                o_miss_cnt <= '0;
                            end
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/ilkn_frame_sync.sv
module ilkn_frame_sync
    import ilkn_fs_pkg::*;
#(
    parameter int LEN_W       = 14,
    parameter int SYNC_NEEDED = 4,
    parameter int MISS_LIMIT  = 3,
    localparam int MISS_W = $clog2(MISS_LIMIT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [66:0]       i_word,
    input  logic [LEN_W-1:0]  i_mf_len,
    output logic              o_locked,
    output logic              o_mf_start,
    output logic              o_mismatch,
    output logic [MISS_W-1:0] o_miss_cnt,
    output logic              o_lock_lost
);
    word_info_t       info;
    fs_state_e        state;
    logic             restart, advance;
    logic [LEN_W-1:0] pos;

    ilkn_fs_classify u_class (
        .i_word (i_word),
        .o_info (info)
    );

    ilkn_fs_position #(.LEN_W(LEN_W)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .i_restart (restart),
        .i_advance (advance),
        .i_len     (i_mf_len),
        .o_pos     (pos)
    );

    ilkn_fs_lock_fsm #(
        .LEN_W       (LEN_W),
        .SYNC_NEEDED (SYNC_NEEDED),
        .MISS_LIMIT  (MISS_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .i_valid     (i_valid),
        .i_info      (info),
        .i_pos       (pos),
        .o_state     (state),
        .o_restart   (restart),
        .o_advance   (advance),
        .o_mf_start  (o_mf_start),
        .o_mismatch  (o_mismatch),
        .o_lock_lost (o_lock_lost),
        .o_miss_cnt  (o_miss_cnt)
    );

    assign o_locked = (state == ST_LOCKED);
endmodule

// File: rtl/ilkn_frame_sync_chk.sv
module ilkn_frame_sync_chk #(
    parameter int MISS_LIMIT = 3,
    localparam int MISS_W = $clog2(MISS_LIMIT)
) (
    input logic              clk,
    input logic              rst,
    input logic              i_valid,
    input logic              o_locked,
    input logic              o_mf_start,
    input logic              o_mismatch,
    input logic [MISS_W-1:0] o_miss_cnt,
    input logic              o_lock_lost
);
    // R6: a start strobe only while lock was already held
    p_start_when_locked_r6: assert property (@(posedge clk) disable iff (rst)
        o_mf_start |-> (o_locked && $past(o_locked)));

    // R3: lock can only rise on an accepted word
    p_lock_rise_valid_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(o_locked) |-> $past(i_valid));

    // R7: lock falls only together with the loss strobe and a failure strobe
    p_lock_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(o_locked) |-> (o_lock_lost && o_mismatch));

    // R7: failure run stays below its limit
    p_miss_bound_r7: assert property (@(posedge clk) disable iff (rst)
        o_miss_cnt < MISS_W'(MISS_LIMIT));

    // R8: no failure run is held while unlocked
    p_miss_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !o_locked |-> (o_miss_cnt == '0));

    // R10: idle cycles give no strobe
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(i_valid) |-> (!o_mf_start && !o_mismatch && !o_lock_lost));

    // R5: start and failure strobes belong to different word indices
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o_mf_start, o_mismatch}));
endmodule

bind ilkn_frame_sync ilkn_frame_sync_chk #(.MISS_LIMIT(MISS_LIMIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .i_valid     (i_valid),
    .o_locked    (o_locked),
    .o_mf_start  (o_mf_start),
    .o_mismatch  (o_mismatch),
    .o_miss_cnt  (o_miss_cnt),
    .o_lock_lost (o_lock_lost)
);

// File: tb/sim_ilkn_frame_sync.sv
`timescale 1ns/1ps
module sim_ilkn_frame_sync;
    localparam int LEN_W = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              i_valid = 1'b0;
    logic [66:0]       i_word = '0;
    logic [LEN_W-1:0]  i_mf_len = 14'd8;
    logic              o_locked, o_mf_start, o_mismatch, o_lock_lost;
    logic [1:0]        o_miss_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    ilkn_frame_sync u0 (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_word(i_word),
        .i_mf_len(i_mf_len), .o_locked(o_locked), .o_mf_start(o_mf_start),
        .o_mismatch(o_mismatch), .o_miss_cnt(o_miss_cnt), .o_lock_lost(o_lock_lost)
    );

    localparam logic [63:0] SYNC64 = 64'h78F6_78F6_78F6_78F6;

    // reference model state
    int          m_st, m_cnt, m_pos, m_miss, m_len;
    logic [57:0] m_ref;
    bit          e_start, e_mm, e_lost;

    function automatic logic [66:0] w_sync();
        return {1'b0, 2'b10, SYNC64};
    endfunction
    function automatic logic [66:0] w_scr(input logic [57:0] s);
        return {1'b0, 2'b10, 6'b001010, s};
    endfunction
    function automatic logic [66:0] w_data();
        return {1'b0, 2'b01, $urandom, $urandom};
    endfunction
    function automatic bit b_sync(input logic [66:0] w);
        return (w[65:64] == 2'b10) && (w[63:0] == SYNC64);
    endfunction
    function automatic bit b_scr(input logic [66:0] w);
        return (w[65:64] == 2'b10) && (w[63:58] == 6'b001010);
    endfunction

    // mode: 0 good, 1 other control type, 2 data header with scr payload, 3 wrong value
    function automatic logic [66:0] fw(input int idx, input bit sync_ok, input int mode,
                                       input logic [57:0] sv, input int extra);
        if (idx == 0) return sync_ok ? w_sync() : w_data();
        if (idx == 1) begin
            case (mode)
                1: return {1'b0, 2'b10, 6'b000011, sv};
                2: return {1'b0, 2'b01, 6'b001010, sv};
                3: return w_scr(sv ^ 58'h1);
                default: return w_scr(sv);
            endcase
        end
        if (idx == extra) return w_sync();
        return w_data();
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_pos = 0; m_miss = 0; m_ref = '0;
        e_start = 0; e_mm = 0; e_lost = 0;
    endtask

    task automatic model(input logic v, input logic [66:0] w);
        int idx;
        bit sy, sc, bad;
        e_start = 0; e_mm = 0; e_lost = 0;
        if (v) begin
            sy = b_sync(w);
            sc = b_scr(w);
            if (m_st == 0) begin
                if (sy) begin m_st = 1; m_cnt = 1; m_pos = 1; end
            end else begin
                idx   = m_pos;
                m_pos = (m_pos == m_len - 1) ? 0 : m_pos + 1;
                if (m_st == 1) begin
                    if (idx == 0) begin
                        if (!sy) begin m_st = 0; m_cnt = 0; end
                        else if (m_cnt == 3) begin m_st = 2; m_miss = 0; end
                        else m_cnt++;
                    end else if (sy) begin
                        m_st = 0; m_cnt = 0;
                    end else if (idx == 1 && sc) begin
                        m_ref = w[57:0];
                    end
                end else begin
                    if (idx == 0 && sy) e_start = 1;
                    if (idx == 1) begin
                        bad = !sc || (w[57:0] != m_ref);
                        if (sc) m_ref = w[57:0];
                        if (bad) begin
                            e_mm = 1;
                            if (m_miss == 2) begin
                                m_st = 0; m_cnt = 0; m_miss = 0; e_lost = 1;
                            end else m_miss++;
                        end else m_miss = 0;
                    end
                end
            end
        end
    endtask

    task automatic put(input logic v, input logic [66:0] w);
        @(negedge clk);
        i_valid = v;
        i_word  = w;
        @(posedge clk);
        #1;
        model(v, w);
        check("R3", "o_locked",    8'(o_locked),    8'(m_st == 2));
        check("R6", "o_mf_start",  8'(o_mf_start),  8'(e_start));
        check("R5", "o_mismatch",  8'(o_mismatch),  8'(e_mm));
        check("R7", "o_lock_lost", 8'(o_lock_lost), 8'(e_lost));
        check("R8", "o_miss_cnt",  8'(o_miss_cnt),  8'(m_miss));
    endtask

    task automatic send_frame(input int len, input bit sync_ok, input int mode,
                              input logic [57:0] sv, input bit gaps, input int extra);
        for (int k = 0; k < len; k++) begin
            if (gaps && ($urandom % 4 == 0)) put(1'b0, w_sync());
            put(1'b1, fw(k, sync_ok, mode, sv, extra));
        end
    endtask

    task automatic tail(input int from, input int len);
        for (int k = from; k < len; k++) put(1'b1, w_data());
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst = 1'b1; i_valid = 1'b0; i_mf_len = LEN_W'(len);
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        m_len = len;
        check("R1", "reset o_locked",    8'(o_locked),    8'h0);
        check("R1", "reset o_mf_start",  8'(o_mf_start),  8'h0);
        check("R1", "reset o_mismatch",  8'(o_mismatch),  8'h0);
        check("R1", "reset o_lock_lost", 8'(o_lock_lost), 8'h0);
        check("R1", "reset o_miss_cnt",  8'(o_miss_cnt),  8'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [57:0] sv;
        int L;
        void'($urandom(32'd20240611));
        L  = 8;
        sv = 58'h2A5_F00D_1234;
        do_reset(L);

        // R2: data-header word with the sync payload does not start a hunt
        put(1'b1, {1'b0, 2'b01, SYNC64});
        put(1'b1, w_sync());
        tail(1, L);
        // now confirming with count 1; after three more boundaries lock (R3)
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R3", "not locked after three", 8'(o_locked), 8'h0);
        put(1'b1, w_sync());
        check("R3", "locked after fourth", 8'(o_locked), 8'h1);
        check("R6", "no strobe on locking word", 8'(o_mf_start), 8'h0);
        put(1'b1, w_scr(sv));
        tail(2, L);

        // R6: strobe on locked sync
        put(1'b1, w_sync());
        check("R6", "strobe while locked", 8'(o_mf_start), 8'h1);
        put(1'b1, w_scr(sv));
        check("R8", "good check keeps count 0", 8'(o_miss_cnt), 8'h0);
        tail(2, L);

        // R7/R8: one failure then a good check
        put(1'b1, w_sync());
        put(1'b1, fw(1, 1, 1, sv, -1));
        check("R7", "failure strobe", 8'(o_mismatch), 8'h1);
        check("R7", "failure count 1", 8'(o_miss_cnt), 8'h1);
        tail(2, L);
        put(1'b1, w_sync());
        put(1'b1, w_scr(sv));
        check("R8", "good check clears count", 8'(o_miss_cnt), 8'h0);
        tail(2, L);

        // R2: scrambler payload with data header fails
        put(1'b1, w_sync());
        put(1'b1, fw(1, 1, 2, sv, -1));
        check("R2", "data header scr word fails", 8'(o_mismatch), 8'h1);
        tail(2, L);
        send_frame(L, 1, 0, sv, 0, -1);

        // R5: wrong state value fails, and so does the restore
        put(1'b1, w_sync());
        put(1'b1, fw(1, 1, 3, sv, -1));
        check("R5", "wrong state value", 8'(o_mismatch), 8'h1);
        tail(2, L);
        put(1'b1, w_sync());
        put(1'b1, w_scr(sv));
        check("R5", "ref follows last word", 8'(o_mismatch), 8'h1);
        check("R5", "run of two", 8'(o_miss_cnt), 8'h2);
        tail(2, L);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R8", "run cleared", 8'(o_miss_cnt), 8'h0);

        // R9: missing sync and extra sync while locked
        put(1'b1, w_data());
        check("R9", "no strobe on missing sync", 8'(o_mf_start), 8'h0);
        check("R9", "lock kept", 8'(o_locked), 8'h1);
        put(1'b1, w_scr(sv));
        tail(2, 4);
        put(1'b1, w_sync());
        check("R9", "no strobe off boundary", 8'(o_mf_start), 8'h0);
        tail(5, L);

        // R10: gaps do not move the position
        put(1'b0, w_sync());
        put(1'b0, w_data());
        put(1'b1, w_sync());
        check("R10", "strobe after gaps", 8'(o_mf_start), 8'h1);
        put(1'b0, w_scr(58'h0));
        check("R10", "gap gives no strobe", 8'(o_mismatch), 8'h0);
        put(1'b1, w_scr(sv));
        tail(2, L);

        // R7: three consecutive failures drop lock
        send_frame(L, 1, 1, sv, 0, -1);
        send_frame(L, 1, 1, sv, 0, -1);
        put(1'b1, w_sync());
        put(1'b1, fw(1, 1, 1, sv, -1));
        check("R7", "lock dropped", 8'(o_locked), 8'h0);
        check("R7", "loss strobe", 8'(o_lock_lost), 8'h1);
        check("R7", "count cleared", 8'(o_miss_cnt), 8'h0);
        tail(2, L);

        // R4: missing boundary sync during confirmation
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 0, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R4", "restart after missing sync", 8'(o_locked), 8'h0);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R3", "relock", 8'(o_locked), 8'h1);

        // R4: misplaced sync during confirmation
        do_reset(L);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, 4);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R4", "restart after misplaced sync", 8'(o_locked), 8'h0);
        send_frame(L, 1, 0, sv, 0, -1);
        check("R3", "lock after restart", 8'(o_locked), 8'h1);

        // random phase against the model
        for (int run = 0; run < 3; run++) begin
            L  = 4 + int'($urandom % 17);
            sv = {$urandom, $urandom};
            do_reset(L);
            for (int f = 0; f < 120; f++) begin
                int r;
                int mode;
                int extra;
                r     = int'($urandom % 100);
                mode  = (r < 8) ? 1 : (r < 12) ? 2 : (r < 18) ? 3 : 0;
                extra = ($urandom % 20 == 0) ? 2 + int'($urandom % (L - 2)) : -1;
                send_frame(L, ($urandom % 10) != 0, mode, sv, ($urandom % 3) == 0, extra);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule